// File: doc/BRIEF.md
# Page-Decoded SPI Byte Bridge

This block connects a narrow host access port to a SPI flash device, one byte at a time. The host sees eight byte-wide offsets. Offsets 0 to 3 hold a 32-bit target address, least significant byte at offset 0. Offset 4 is a data port. Offsets 5 to 7 are unused.

The block has no command or length registers. Each data-port access is decoded by the page that bits 31..8 of the stored address select. One page releases chip select. A second page asserts chip select and runs one byte through a mode-0 shifter: a write sends the written byte, and a read sends 0xFF and returns the byte captured from MISO. A data access to any other page does nothing. After reset, address bytes 0, 2 and 3 already hold 0x00, 0xFF and 0xFF. Software therefore only rewrites byte 1 to move between the release page (0xFE) and the select page (0xFD).

A flash transaction is built from a release access, then up to 64 write bytes, then up to 64 read bytes, then a second release access. The busy output stays high while a byte is shifting. The host must wait for busy to fall before the next access. An access made while busy is high is dropped.

Top module: `spi_page_bridge`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and acc_busy is 0. Address bytes at offsets 0,1,2,3 read back as 0x00, 0x00, 0xFF, 0xFF.
- R2: A write to offset 0..3 stores acc_wdata as address byte 0..3, where byte 0 is bits 7..0 and byte 3 is bits 31..24. A read of offset 0..3 raises acc_rvalid one cycle after the accepting edge, with that byte on acc_rdata.
- R3: When address bits 31..8 equal 0xFFFFFE, a data-port (offset 4) access of either kind sets spi_cs_n to 1 one cycle after the accepting edge and produces no SCLK edge. Such a read returns 0xFF.
- R4: When address bits 31..8 equal 0xFFFFFD, a data-port write drives spi_cs_n to 0 one cycle after the accepting edge. It then sends acc_wdata on spi_mosi, MSB first, in SPI mode 0: SCLK idles low, MOSI is stable while SCLK is high, and the first bit is presented before the first rising edge.
- R5: When address bits 31..8 equal 0xFFFFFD, a data-port read drives spi_cs_n to 0 and sends 0xFF. It samples spi_miso on each rising SCLK edge, MSB first. It returns the byte with acc_rvalid in the cycle acc_busy falls.
- R6: For a shifted byte, acc_busy is high for exactly 16*DIV_HALF cycles after the accepting edge. Each SCLK level lasts DIV_HALF cycles, and SCLK is low whenever acc_busy is low.
- R7: Any access presented while acc_busy is high is ignored. Address bytes, spi_cs_n and the byte being shifted are unaffected.
- R8: A data-port access whose page is neither 0xFFFFFE nor 0xFFFFFD leaves spi_cs_n unchanged and shifts nothing. Such a read returns 0xFF one cycle later.
- R9: Writes to offsets 5..7 have no effect, and reads of them return 0xFF one cycle later.
- R10: Address bits 7..0 do not take part in page decode.
- R11: spi_cs_n stays low across consecutive select-page bytes (up to 64 written and then 64 read) until a release-page access, and the bytes go out and come back in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_off | input | 3 | Offset of the host access |
| acc_wr | input | 1 | Write strobe, one cycle; wins if acc_rd is also high |
| acc_rd | input | 1 | Read strobe, one cycle |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read result, valid while acc_rvalid is high |
| acc_rvalid | output | 1 | One-cycle read completion pulse |
| acc_busy | output | 1 | High while a byte is being shifted |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench targets several corner cases and names the wrong behaviour each one would expose:
- Changing the low address byte inside the select page. A decoder that compared all 32 bits would stop shifting at that point.
- Rewriting the address and the data port while a byte is still shifting. A design that accepted these accesses would corrupt the page or start a second byte early.
- Data accesses to a foreign page while chip select is low. A design that defaulted to release would drop chip select in the middle of a transaction.
- A 64-byte write run followed by a 64-byte read run. Any off-by-one in the bit counter, or a misplaced MISO sample edge, would show up as shifted or rotated bytes.

// File: rtl/spi_page_bridge_pkg.sv
package spi_page_bridge_pkg;
  localparam int ADDR_BYTES = 4;
  localparam int ADDR_W     = ADDR_BYTES * 8;
  localparam int OFF_W      = 3;
  localparam int BYTE_BITS  = 8;
  localparam logic [OFF_W-1:0] DATA_OFF = 3'd4;

  typedef enum logic [1:0] {
    PG_NONE    = 2'd0,
    PG_RELEASE = 2'd1,
    PG_SELECT  = 2'd2
  } page_e;
endpackage

// File: rtl/spi_page_bridge_rst.sv
module spi_page_bridge_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/spi_page_bridge_addr.sv
module spi_page_bridge_addr
  import spi_page_bridge_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_INIT = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        idx,
  input  logic [7:0]        wdata,
  output logic [ADDR_W-1:0] addr
);
  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic       byte_en;
    assign byte_en = we && (idx == 2'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= ADDR_INIT[b*8 +: 8];
      else if (byte_en) byte_q <= wdata;
    end

    assign addr[b*8 +: 8] = byte_q;
  end
endmodule

// File: rtl/spi_page_bridge_shift.sv
module spi_page_bridge_shift
  import spi_page_bridge_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BYTE_BITS-1:0] tx_byte,
  input  logic                 miso,
  output logic                 busy,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 done,
  output logic [BYTE_BITS-1:0] rx_byte
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BW = $clog2(BYTE_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_BITS - 1);

  logic                 busy_q, busy_d;
  logic                 sclk_q, sclk_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [BYTE_BITS-1:0] sh_q, sh_d;
  logic [BYTE_BITS-1:0] rx_q, rx_d;
  logic                 tick;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        cnt_d  = '0;
        bit_d  = '0;
        sh_d   = tx_byte;
      end
    end else if (tick) begin
      cnt_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[BYTE_BITS-2:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bit_q == BIT_LAST) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          sh_d  = {sh_q[BYTE_BITS-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[BYTE_BITS-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_page_bridge.sv
module spi_page_bridge
  import spi_page_bridge_pkg::*;
#(
  parameter int                DIV_HALF  = 2,
  parameter logic [ADDR_W-9:0] REL_PAGE  = 24'hFFFFFE,
  parameter logic [ADDR_W-9:0] SEL_PAGE  = 24'hFFFFFD,
  parameter logic [ADDR_W-1:0] ADDR_INIT = 32'hFFFF_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] acc_off,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [7:0]       acc_wdata,
  output logic [7:0]       acc_rdata,
  output logic             acc_rvalid,
  output logic             acc_busy,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  logic              rst_n_i;
  logic [ADDR_W-1:0] addr_w;
  logic              addr_we;
  logic              sh_start, sh_busy, sh_done;
  logic [7:0]        sh_tx, sh_rx;
  logic              accept, is_wr, is_rd;
  page_e             page;

  logic       cs_q, cs_d;
  logic       rv_q, rv_d;
  logic [7:0] rdata_q, rdata_d;
  logic       pend_q, pend_d;

  spi_page_bridge_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  spi_page_bridge_addr #(.ADDR_INIT(ADDR_INIT)) u_addr (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (addr_we),
    .idx   (acc_off[1:0]),
    .wdata (acc_wdata),
    .addr  (addr_w)
  );

  spi_page_bridge_shift #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .busy    (sh_busy),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  assign accept = (acc_wr || acc_rd) && !sh_busy;
  assign is_wr  = acc_wr;
  assign is_rd  = acc_rd && !acc_wr;

  always_comb begin
    if (addr_w[ADDR_W-1:8] == REL_PAGE)      page = PG_RELEASE;
    else if (addr_w[ADDR_W-1:8] == SEL_PAGE) page = PG_SELECT;
    else                                     page = PG_NONE;
  end

  always_comb begin
    cs_d     = cs_q;
    rv_d     = 1'b0;
    rdata_d  = rdata_q;
    pend_d   = pend_q;
    addr_we  = 1'b0;
    sh_start = 1'b0;
    sh_tx    = IDLE_BYTE;
    if (sh_done && pend_q) begin
      rv_d    = 1'b1;
      rdata_d = sh_rx;
      pend_d  = 1'b0;
    end
    if (accept) begin
      if (acc_off < DATA_OFF) begin
        if (is_wr) begin
          addr_we = 1'b1;
        end else begin
          rv_d    = 1'b1;
          rdata_d = addr_w[acc_off[1:0]*8 +: 8];
        end
      end else if (acc_off == DATA_OFF) begin
        case (page)
          PG_RELEASE: begin
            cs_d = 1'b1;
            if (is_rd) begin
              rv_d    = 1'b1;
              rdata_d = IDLE_BYTE;
            end
          end
          PG_SELECT: begin
            cs_d     = 1'b0;
            sh_start = 1'b1;
            sh_tx    = is_wr ? acc_wdata : IDLE_BYTE;
            pend_d   = is_rd;
          end
          default: begin
            if (is_rd) begin
              rv_d    = 1'b1;
              rdata_d = IDLE_BYTE;
            end
          end
        endcase
      end else if (is_rd) begin
        rv_d    = 1'b1;
        rdata_d = IDLE_BYTE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cs_q    <= 1'b1;
      rv_q    <= 1'b0;
      rdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cs_q    <= cs_d;
      rv_q    <= rv_d;
      rdata_q <= rdata_d;
      pend_q  <= pend_d;
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rvalid = rv_q;
  assign acc_busy   = sh_busy;
  assign spi_cs_n   = cs_q;
endmodule

// File: rtl/spi_page_bridge_chk.sv
module spi_page_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic rvalid,
  input logic cs_n,
  input logic sclk,
  input logic mosi
);
  // R6
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R4
  cs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R4
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R5
  rv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rvalid);

  // R7
  cs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cs_n));

  // R6
  sclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(busy));
endmodule

bind spi_page_bridge spi_page_bridge_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (acc_busy),
  .rvalid (acc_rvalid),
  .cs_n   (spi_cs_n),
  .sclk   (spi_sclk),
  .mosi   (spi_mosi)
);

// File: tb/spi_page_bridge_tb.sv
`timescale 1ns/1ps
module spi_page_bridge_tb;
  localparam int DIV_HALF = 2;
  localparam int BYTE_CYC = 16 * DIV_HALF;

  logic       clk;
  logic       rst_n;
  logic [2:0] acc_off;
  logic       acc_wr, acc_rd;
  logic [7:0] acc_wdata;
  logic [7:0] acc_rdata;
  logic       acc_rvalid, acc_busy;
  logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int total = 0;
  int bad   = 0;

  spi_page_bridge #(.DIV_HALF(DIV_HALF)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_off    (acc_off),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .acc_wdata  (acc_wdata),
    .acc_rdata  (acc_rdata),
    .acc_rvalid (acc_rvalid),
    .acc_busy   (acc_busy),
    .spi_cs_n   (spi_cs_n),
    .spi_sclk   (spi_sclk),
    .spi_mosi   (spi_mosi),
    .spi_miso   (spi_miso)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural flash-side responder
  logic [7:0] slv_tx;
  logic [2:0] slv_bits;
  logic [7:0] slv_cap;
  logic [7:0] cap_q[$];

  assign spi_miso = slv_tx[3'd7 - slv_bits];

  always @(posedge spi_sclk or negedge rst_n) begin
    if (!rst_n) begin
      slv_bits = 3'd0;
      slv_cap  = 8'h00;
    end else begin
      slv_cap = {slv_cap[6:0], spi_mosi};
      if (spi_cs_n) begin
        total++; bad++;
        $display("FAIL R4: sclk rise with cs_n=%0b expected 0", spi_cs_n);
      end
      if (slv_bits == 3'd7) cap_q.push_back(slv_cap);
      slv_bits = slv_bits + 3'd1;
    end
  end

  // reference model, updated each rising edge
  logic [7:0] m_a[4];
  logic       m_cs;
  int         m_rem;
  logic       m_isrd;
  logic       m_rv;
  logic [7:0] m_rdata;
  logic [7:0] m_tx;
  logic [23:0] m_page;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a[0] = 8'h00; m_a[1] = 8'h00; m_a[2] = 8'hFF; m_a[3] = 8'hFF;
      m_cs = 1'b1; m_rem = 0; m_isrd = 1'b0; m_rv = 1'b0; m_rdata = 8'h00;
      m_tx = 8'hFF;
    end else begin
      m_rv = 1'b0;
      if (m_rem > 0) begin
        if (m_rem == 1 && m_isrd) begin
          m_rv = 1'b1;
          m_rdata = m_tx;
        end
        m_rem--;
      end else if (acc_wr || acc_rd) begin
        m_page = {m_a[3], m_a[2], m_a[1]};
        if (acc_off < 3'd4) begin
          if (acc_wr) m_a[acc_off[1:0]] = acc_wdata;
          else begin m_rv = 1'b1; m_rdata = m_a[acc_off[1:0]]; end
        end else if (acc_off == 3'd4) begin
          if (m_page == 24'hFFFFFE) begin
            m_cs = 1'b1;
            if (!acc_wr) begin m_rv = 1'b1; m_rdata = 8'hFF; end
          end else if (m_page == 24'hFFFFFD) begin
            m_cs   = 1'b0;
            m_rem  = BYTE_CYC;
            m_isrd = !acc_wr;
            m_tx   = slv_tx;
          end else if (!acc_wr) begin
            m_rv = 1'b1; m_rdata = 8'hFF;
          end
        end else if (!acc_wr) begin
          m_rv = 1'b1; m_rdata = 8'hFF;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (acc_busy !== (m_rem > 0)) begin
        bad++; $display("FAIL R6: busy=%0b expected %0b", acc_busy, (m_rem > 0));
      end
      total++;
      if (spi_cs_n !== m_cs) begin
        bad++; $display("FAIL R3/R4 cs_n=%0b expected %0b", spi_cs_n, m_cs);
      end
      total++;
      if (acc_rvalid !== m_rv) begin
        bad++; $display("FAIL R2/R5 rvalid=%0b expected %0b", acc_rvalid, m_rv);
      end
      if (m_rv) begin
        total++;
        if (acc_rdata !== m_rdata) begin
          bad++; $display("FAIL R2/R5 rdata=%02h expected %02h", acc_rdata, m_rdata);
        end
      end
      if (!acc_busy) begin
        total++;
        if (spi_sclk !== 1'b0) begin
          bad++; $display("FAIL R6: sclk=%0b expected 0 when idle", spi_sclk);
        end
      end
    end
  end

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [7:0] last_rd;
  int         last_busy_cyc;

  task automatic access(input logic wr, input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    acc_wr = wr; acc_rd = !wr; acc_off = off; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; acc_rd = 1'b0;
    last_busy_cyc = 0;
    while (acc_busy) begin
      last_busy_cyc++;
      @(negedge clk);
    end
    last_rd = acc_rdata;
  endtask

  task automatic pop_cap(input string tag, input logic [7:0] exp);
    total++;
    if (cap_q.size() == 0) begin
      bad++; $display("FAIL %s: no captured byte expected %02h", tag, exp);
    end else begin
      logic [7:0] v;
      v = cap_q.pop_front();
      if (v !== exp) begin
        bad++; $display("FAIL %s: mosi byte %02h expected %02h", tag, v, exp);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    acc_off = 3'd0; acc_wr = 1'b0; acc_rd = 1'b0; acc_wdata = 8'h00;
    slv_tx = 8'hFF;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check8("R1 cs_n", {7'd0, spi_cs_n}, 8'h01);
    check8("R1 sclk", {7'd0, spi_sclk}, 8'h00);
    check8("R1 busy", {7'd0, acc_busy}, 8'h00);
    access(1'b0, 3'd0, 8'h00); check8("R1 addr0", last_rd, 8'h00);
    access(1'b0, 3'd1, 8'h00); check8("R1 addr1", last_rd, 8'h00);
    access(1'b0, 3'd2, 8'h00); check8("R1 addr2", last_rd, 8'hFF);
    access(1'b0, 3'd3, 8'h00); check8("R1 addr3", last_rd, 8'hFF);

    // R2 address byte write and readback
    access(1'b1, 3'd0, 8'h5A);
    access(1'b1, 3'd1, 8'hFD);
    access(1'b0, 3'd0, 8'h00); check8("R2 addr0", last_rd, 8'h5A);
    access(1'b0, 3'd1, 8'h00); check8("R2 addr1", last_rd, 8'hFD);

    // R4 + R6 + R10: select-page write with nonzero low byte
    access(1'b1, 3'd4, 8'hA5);
    check_int("R6 busy cycles", last_busy_cyc, BYTE_CYC);
    pop_cap("R4 mosi", 8'hA5);
    check8("R4 cs_n low", {7'd0, spi_cs_n}, 8'h00);
    access(1'b1, 3'd4, 8'h3C);
    pop_cap("R10 mosi", 8'h3C);

    // R5 select-page read
    slv_tx = 8'hC3;
    access(1'b0, 3'd4, 8'h00);
    check8("R5 read", last_rd, 8'hC3);
    pop_cap("R5 mosi idle", 8'hFF);

    // R8 foreign page while cs low
    access(1'b1, 3'd1, 8'h12);
    access(1'b1, 3'd4, 8'h99);
    check8("R8 cs_n kept", {7'd0, spi_cs_n}, 8'h00);
    check_int("R8 no shift", cap_q.size(), 0);
    access(1'b0, 3'd4, 8'h00);
    check8("R8 read", last_rd, 8'hFF);

    // R3 release page
    access(1'b1, 3'd1, 8'hFE);
    access(1'b1, 3'd4, 8'h00);
    check8("R3 cs_n high", {7'd0, spi_cs_n}, 8'h01);
    check_int("R3 no shift", cap_q.size(), 0);
    access(1'b0, 3'd4, 8'h00);
    check8("R3 read", last_rd, 8'hFF);

    // R9 unused offsets
    access(1'b1, 3'd5, 8'h00);
    access(1'b1, 3'd7, 8'h00);
    access(1'b0, 3'd6, 8'h00); check8("R9 read", last_rd, 8'hFF);
    access(1'b0, 3'd1, 8'h00); check8("R9 addr1 intact", last_rd, 8'hFE);
    check8("R9 cs_n", {7'd0, spi_cs_n}, 8'h01);

    // R7 accesses during busy are dropped
    access(1'b1, 3'd1, 8'hFD);
    @(negedge clk);
    acc_wr = 1'b1; acc_off = 3'd4; acc_wdata = 8'h81;
    @(negedge clk);
    acc_off = 3'd1; acc_wdata = 8'hFE;
    @(negedge clk);
    acc_off = 3'd4; acc_wdata = 8'h7E;
    @(negedge clk);
    acc_wr = 1'b0;
    while (acc_busy) @(negedge clk);
    pop_cap("R7 first byte", 8'h81);
    check_int("R7 no extra byte", cap_q.size(), 0);
    access(1'b0, 3'd1, 8'h00); check8("R7 addr1 kept", last_rd, 8'hFD);

    // R11 full transaction: release, 64 writes, 64 reads, release
    access(1'b1, 3'd1, 8'hFE);
    access(1'b1, 3'd4, 8'h00);
    access(1'b1, 3'd1, 8'hFD);
    for (int i = 0; i < 64; i++) begin
      access(1'b1, 3'd4, 8'((i * 37 + 5) & 8'hFF));
      if (spi_cs_n !== 1'b0) begin
        total++; bad++;
        $display("FAIL R11: cs_n=%0b expected 0 at write %0d", spi_cs_n, i);
      end
    end
    for (int i = 0; i < 64; i++) pop_cap("R11 write order", 8'((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < 64; i++) begin
      slv_tx = 8'((i * 53 + 11) & 8'hFF);
      access(1'b0, 3'd4, 8'h00);
      check8("R11 read order", last_rd, 8'((i * 53 + 11) & 8'hFF));
    end
    for (int i = 0; i < 64; i++) pop_cap("R11 read mosi", 8'hFF);
    check8("R11 cs_n held", {7'd0, spi_cs_n}, 8'h00);
    access(1'b1, 3'd1, 8'hFE);
    access(1'b1, 3'd4, 8'h00);
    check8("R11 cs_n released", {7'd0, spi_cs_n}, 8'h01);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule